// File: doc/BRIEF.md
# Rename Physical Register Free List

This block keeps track of which physical register indices are currently unallocated in the rename stage of an out-of-order core. Integer and floating-point registers share one index space. Integer registers occupy the low indices, and floating-point registers start right after the last integer index. Each class has its own first-in-first-out pool of free indices. An allocation always hands out the oldest free entry of the requested class.

Rename logic asks for a register on the integer or floating-point allocate port. The answer comes back in the same cycle as a valid flag plus an index, and the entry leaves the pool at the next clock edge. Retired or squashed registers come back on three release ports: one for integer indices, one for floating-point indices, and one untyped port. The untyped port routes an index by its value. On that port the zero register of each class and any index outside the space are dropped without effect. Asking for a register from an empty pool sets a sticky error flag, which only reset clears.

The reset input is asserted asynchronously and its release is synchronised to the clock, so the block leaves reset two rising edges after `rst_n` goes high.

Top module: `rename_free_list`

## Requirements
- R1: After reset the integer pool holds indices INT_ARCH to INT_PHYS-1 in ascending order (defaults 8..11), so int_free_cnt reads INT_PHYS-INT_ARCH.
- R2: After reset the floating-point pool holds indices INT_PHYS+FP_ARCH to INT_PHYS+FP_PHYS-1 in ascending order (defaults 20..23).
- R3: When an allocate request meets a non-empty pool, the valid output is high in that same cycle and the index is the oldest entry in that pool. That entry is removed at the next rising edge.
- R4: On the untyped release port, an index below INT_PHYS joins the integer pool, and an index from INT_PHYS to INT_PHYS+FP_PHYS-1 joins the floating-point pool.
- R5: The untyped release port drops, with no change to either pool, three kinds of index: ZERO_IDX, ZERO_IDX+INT_PHYS, and any index at or above INT_PHYS+FP_PHYS.
- R6: The typed integer and floating-point release ports append whatever index they are given, zero registers included, with no filtering.
- R7: An allocate request on an empty pool returns valid low and leaves the pool unchanged. alloc_err is high from the next cycle and stays high until reset.
- R8: An allocation and releases on the same pool in one cycle are all honoured, and the count changes by the net amount. When both the typed and the untyped port release into the same pool in one cycle, the typed entry is queued ahead of the untyped one.
- R9: int_avail and fp_avail are high exactly when the matching count is non-zero. The counts equal the number of entries in each pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_alloc_req | input | 1 | Request an integer register |
| int_alloc_vld | output | 1 | Integer allocation granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer index |
| fp_alloc_req | input | 1 | Request a floating-point register |
| fp_alloc_vld | output | 1 | Floating-point allocation granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted floating-point index |
| int_rel_vld | input | 1 | Typed integer release strobe |
| int_rel_idx | input | IDX_W | Index returned to the integer pool |
| fp_rel_vld | input | 1 | Typed floating-point release strobe |
| fp_rel_idx | input | IDX_W | Index returned to the floating-point pool |
| any_rel_vld | input | 1 | Untyped release strobe |
| any_rel_idx | input | IDX_W | Index routed by range |
| int_avail | output | 1 | Integer pool not empty |
| fp_avail | output | 1 | Floating-point pool not empty |
| int_free_cnt | output | ICNT_W | Free integer entries |
| fp_free_cnt | output | FCNT_W | Free floating-point entries |
| alloc_err | output | 1 | Sticky flag: allocation tried on an empty pool |

## Verification
Two things can land on one pool in the same clock edge: an allocation pop, and up to two pushes, one from the typed port and one routed from the untyped port. Directed cycles drive all three at once against the integer pool. The bench then drains the pool to confirm that the count moved by the net amount and that the typed entry comes out before the untyped one. A long random phase later mixes allocations with releases drawn from indices already handed out. A queue-based reference model checks every grant, count and flag on every clock.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

  // Route decision for an index arriving on the untyped release port
  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_INT  = 2'd1,
    RT_FP   = 2'd2
  } route_e;

  // Circular pointer advance for a buffer of arbitrary depth
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rfl_router.sv
module rfl_router #(
  parameter int IDX_W    = 5,
  parameter int INT_PHYS = 12,
  parameter int TOTAL    = 24,
  parameter int ZERO_IDX = 0
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic             to_int,
  output logic             to_fp
);
  import rfl_pkg::*;

  localparam logic [IDX_W:0] INT_LIM = (IDX_W+1)'(INT_PHYS);
  localparam logic [IDX_W:0] TOT_LIM = (IDX_W+1)'(TOTAL);
  localparam logic [IDX_W:0] Z_INT   = (IDX_W+1)'(ZERO_IDX);
  localparam logic [IDX_W:0] Z_FP    = (IDX_W+1)'(ZERO_IDX + INT_PHYS);

  route_e     route;
  logic [IDX_W:0] wide;

  assign wide = {1'b0, idx};

  always_comb begin
    route = RT_DROP;
    if (vld) begin
      if (wide < INT_LIM) begin
        if (wide != Z_INT) route = RT_INT;
      end else if (wide < TOT_LIM) begin
        if (wide != Z_FP) route = RT_FP;
      end
    end
  end

  assign to_int = (route == RT_INT);
  assign to_fp  = (route == RT_FP);

endmodule

// File: rtl/rfl_pool.sv
module rfl_pool #(
  parameter int IDX_W     = 5,
  parameter int DEPTH     = 12,
  parameter int INIT_N    = 4,
  parameter int INIT_BASE = 8,
  localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_req,
  input  logic             push_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic             push_b,
  input  logic [IDX_W-1:0] idx_b,
  output logic [IDX_W-1:0] head_idx,
  output logic             nonempty,
  output logic [CNT_W-1:0] count
);
  import rfl_pkg::*;

  logic [IDX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head, tail, head_n, tail_n, t1, t2, wr_a, wr_b;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             pop_go;

  // Next-state logic
  always_comb begin
    pop_go = pop_req & (cnt != '0);
    t1     = PTR_W'(ptr_step(int'(tail), DEPTH));
    t2     = PTR_W'(ptr_step(int'(t1), DEPTH));
    wr_a   = tail;
    wr_b   = push_a ? t1 : tail;
    if (push_a & push_b)      tail_n = t2;
    else if (push_a | push_b) tail_n = t1;
    else                      tail_n = tail;
    head_n = pop_go ? PTR_W'(ptr_step(int'(head), DEPTH)) : head;
    cnt_n  = cnt + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop_go);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= PTR_W'(INIT_N % DEPTH);
      cnt  <= CNT_W'(INIT_N);
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i < INIT_N) ? IDX_W'(INIT_BASE + i) : '0;
    end else begin
      if (push_a) mem[wr_a] <= idx_a;
      if (push_b) mem[wr_b] <= idx_b;
      head <= head_n;
      tail <= tail_n;
      cnt  <= cnt_n;
    end
  end

  assign head_idx = mem[head];
  assign nonempty = (cnt != '0);
  assign count    = cnt;

  // R9: occupancy never exceeds the storage
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R3: without a pop the oldest entry stays at the head
  a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_req && nonempty) |=> $stable(head_idx));

  // R8: two pushes and a pop in one cycle leave a net gain of one
  a_r8_net_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_a && push_b && pop_req && nonempty) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int IDX_W    = 5,
  parameter int INT_ARCH = 8,
  parameter int INT_PHYS = 12,
  parameter int FP_ARCH  = 8,
  parameter int FP_PHYS  = 12,
  parameter int ZERO_IDX = 0,
  localparam int ICNT_W  = $clog2(INT_PHYS + 1),
  localparam int FCNT_W  = $clog2(FP_PHYS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_alloc_req,
  output logic              int_alloc_vld,
  output logic [IDX_W-1:0]  int_alloc_idx,
  input  logic              fp_alloc_req,
  output logic              fp_alloc_vld,
  output logic [IDX_W-1:0]  fp_alloc_idx,
  input  logic              int_rel_vld,
  input  logic [IDX_W-1:0]  int_rel_idx,
  input  logic              fp_rel_vld,
  input  logic [IDX_W-1:0]  fp_rel_idx,
  input  logic              any_rel_vld,
  input  logic [IDX_W-1:0]  any_rel_idx,
  output logic              int_avail,
  output logic              fp_avail,
  output logic [ICNT_W-1:0] int_free_cnt,
  output logic [FCNT_W-1:0] fp_free_cnt,
  output logic              alloc_err
);
  localparam int TOTAL = INT_PHYS + FP_PHYS;

  logic [1:0] rst_sync;
  logic       rst_i;
  logic       to_int, to_fp;
  logic       err, err_n;

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  rfl_router #(
    .IDX_W(IDX_W), .INT_PHYS(INT_PHYS), .TOTAL(TOTAL), .ZERO_IDX(ZERO_IDX)
  ) u_route (
    .vld(any_rel_vld), .idx(any_rel_idx), .to_int(to_int), .to_fp(to_fp)
  );

  rfl_pool #(
    .IDX_W(IDX_W), .DEPTH(INT_PHYS),
    .INIT_N(INT_PHYS - INT_ARCH), .INIT_BASE(INT_ARCH)
  ) u_int_pool (
    .clk(clk), .rst_n(rst_i), .pop_req(int_alloc_req),
    .push_a(int_rel_vld), .idx_a(int_rel_idx),
    .push_b(to_int), .idx_b(any_rel_idx),
    .head_idx(int_alloc_idx), .nonempty(int_avail), .count(int_free_cnt)
  );

  rfl_pool #(
    .IDX_W(IDX_W), .DEPTH(FP_PHYS),
    .INIT_N(FP_PHYS - FP_ARCH), .INIT_BASE(INT_PHYS + FP_ARCH)
  ) u_fp_pool (
    .clk(clk), .rst_n(rst_i), .pop_req(fp_alloc_req),
    .push_a(fp_rel_vld), .idx_a(fp_rel_idx),
    .push_b(to_fp), .idx_b(any_rel_idx),
    .head_idx(fp_alloc_idx), .nonempty(fp_avail), .count(fp_free_cnt)
  );

  assign int_alloc_vld = int_alloc_req & int_avail;
  assign fp_alloc_vld  = fp_alloc_req & fp_avail;

  always_comb begin
    err_n = err | (int_alloc_req & ~int_avail) | (fp_alloc_req & ~fp_avail);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) err <= 1'b0;
    else        err <= err_n;
  end
  assign alloc_err = err;

  // R7: the error flag never clears on its own
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    alloc_err |=> alloc_err);

  // R7: a request on an empty pool raises the flag next cycle
  a_r7_empty_req: assert property (@(posedge clk) disable iff (!rst_i)
    ((int_alloc_req && !int_avail) || (fp_alloc_req && !fp_avail)) |=> alloc_err);

  // R3: a grant is only given from a pool that holds entries
  a_r3_grant_nonempty: assert property (@(posedge clk) disable iff (!rst_i)
    (int_alloc_vld |-> int_free_cnt != '0) and (fp_alloc_vld |-> fp_free_cnt != '0));

  // R5: zero registers are never routed into a pool
  a_r5_zero_dropped: assert property (@(posedge clk) disable iff (!rst_i)
    (any_rel_vld && (any_rel_idx == IDX_W'(ZERO_IDX) ||
                     any_rel_idx == IDX_W'(ZERO_IDX + INT_PHYS))) |-> (!to_int && !to_fp));

  // R4: out-of-range indices are discarded, in-range ones go to exactly one pool
  a_r4_route_range: assert property (@(posedge clk) disable iff (!rst_i)
    ({1'b0, any_rel_idx} >= (IDX_W+1)'(TOTAL) |-> (!to_int && !to_fp)) and
    !(to_int && to_fp));

endmodule

// File: tb/rename_free_list_tb.sv
`timescale 1ns/1ps
module rename_free_list_tb;
  localparam int IW = 5, IA = 8, IP = 12, FA = 8, FP = 12, Z = 0;

  logic clk = 1'b0;
  logic rst_n;
  logic ia, fa, irv, frv, arv;
  logic [IW-1:0] iri, fri, ari;
  logic int_alloc_vld, fp_alloc_vld, int_avail, fp_avail, alloc_err;
  logic [IW-1:0] int_alloc_idx, fp_alloc_idx;
  logic [3:0] int_free_cnt, fp_free_cnt;

  int checks = 0, fails = 0;
  int iq[$], fq[$], oi[$], of_[$];
  bit merr;
  int last_i, last_f;
  bit done = 0;

  always #2.5 clk = ~clk;

  rename_free_list #(.IDX_W(IW), .INT_ARCH(IA), .INT_PHYS(IP),
                     .FP_ARCH(FA), .FP_PHYS(FP), .ZERO_IDX(Z)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .int_alloc_req(ia), .int_alloc_vld(int_alloc_vld), .int_alloc_idx(int_alloc_idx),
    .fp_alloc_req(fa), .fp_alloc_vld(fp_alloc_vld), .fp_alloc_idx(fp_alloc_idx),
    .int_rel_vld(irv), .int_rel_idx(iri), .fp_rel_vld(frv), .fp_rel_idx(fri),
    .any_rel_vld(arv), .any_rel_idx(ari),
    .int_avail(int_avail), .fp_avail(fp_avail),
    .int_free_cnt(int_free_cnt), .fp_free_cnt(fp_free_cnt), .alloc_err(alloc_err));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    iq.delete(); fq.delete(); oi.delete(); of_.delete();
    for (int i = IA; i < IP; i++) iq.push_back(i);
    for (int i = IP + FA; i < IP + FP; i++) fq.push_back(i);
    merr = 0;
  endtask

  task automatic compare(string tag);
    chk({tag, " R3 int vld"}, int_alloc_vld, (ia && iq.size() > 0));
    if (ia && iq.size() > 0) chk({tag, " R3 int idx"}, int_alloc_idx, iq[0]);
    chk({tag, " R3 fp vld"}, fp_alloc_vld, (fa && fq.size() > 0));
    if (fa && fq.size() > 0) chk({tag, " R3 fp idx"}, fp_alloc_idx, fq[0]);
    chk({tag, " R9 int cnt"}, int_free_cnt, iq.size());
    chk({tag, " R9 fp cnt"}, fp_free_cnt, fq.size());
    chk({tag, " R9 int avail"}, int_avail, iq.size() > 0);
    chk({tag, " R9 fp avail"}, fp_avail, fq.size() > 0);
    chk({tag, " R7 err"}, alloc_err, merr);
  endtask

  task automatic model_update();
    bit ie = (iq.size() == 0), fe = (fq.size() == 0);
    if (ia) begin
      if (!ie) oi.push_back(iq.pop_front()); else merr = 1;
    end
    if (fa) begin
      if (!fe) of_.push_back(fq.pop_front()); else merr = 1;
    end
    if (irv) iq.push_back(int'(iri));
    if (frv) fq.push_back(int'(fri));
    if (arv) begin
      if (ari < IP) begin
        if (ari != Z) iq.push_back(int'(ari));
      end else if (ari < IP + FP) begin
        if (ari != Z + IP) fq.push_back(int'(ari));
      end
    end
  endtask

  // Called just after a falling edge; returns just after the next one
  task automatic step(string tag, bit a_i, bit a_f, bit r_i, int i_i,
                      bit r_f, int i_f, bit r_a, int i_a);
    ia = a_i; fa = a_f; irv = r_i; iri = IW'(i_i);
    frv = r_f; fri = IW'(i_f); arv = r_a; ari = IW'(i_a);
    #1;
    compare(tag);
    last_i = int'(int_alloc_idx); last_f = int'(fp_alloc_idx);
    @(posedge clk);
    model_update();
    @(negedge clk);
    ia = 0; fa = 0; irv = 0; frv = 0; arv = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ia = 0; fa = 0; irv = 0; frv = 0; arv = 0; iri = '0; fri = '0; ari = '0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2: reset contents
    #1;
    compare("reset");
    chk("R1 reset int count", int_free_cnt, IP - IA);
    chk("R2 reset fp count", fp_free_cnt, FP - FA);
    chk("R7 reset err clear", alloc_err, 0);
    @(negedge clk);

    // R1: integer pool drains in ascending order
    for (int k = 0; k < 4; k++) begin
      step("R1 drain", 1, 0, 0, 0, 0, 0, 0, 0);
      chk("R1 int order", last_i, IA + k);
    end
    // R2: floating-point pool first entries
    for (int k = 0; k < 2; k++) begin
      step("R2 drain", 0, 1, 0, 0, 0, 0, 0, 0);
      chk("R2 fp order", last_f, IP + FA + k);
    end
    chk("R9 int avail low when empty", int_avail, 0);

    // R4 / R5: untyped routing and drops
    step("R4 any int", 0, 0, 0, 0, 0, 0, 1, 5);
    chk("R4 untyped 5 reaches int pool", int_free_cnt, 1);
    step("R5 zero int", 0, 0, 0, 0, 0, 0, 1, Z);
    chk("R5 int zero dropped", int_free_cnt, 1);
    step("R5 zero fp", 0, 0, 0, 0, 0, 0, 1, Z + IP);
    chk("R5 fp zero dropped", fp_free_cnt, 2);
    step("R5 out of range", 0, 0, 0, 0, 0, 0, 1, 30);
    chk("R5 out of range int cnt", int_free_cnt, 1);
    chk("R5 out of range fp cnt", fp_free_cnt, 2);
    step("R4 any fp", 0, 0, 0, 0, 0, 0, 1, 13);
    chk("R4 untyped 13 reaches fp pool", fp_free_cnt, 3);

    // R6: typed ports do not filter
    step("R6 typed int zero", 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R6 typed int zero kept", int_free_cnt, 2);
    step("R6 typed fp zero", 0, 0, 0, 0, 1, Z + IP, 0, 0);
    chk("R6 typed fp zero kept", fp_free_cnt, 4);
    step("R3 fifo", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 oldest first", last_i, 5);
    step("R6 zero out", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 typed zero allocated", last_i, 0);

    // R8: simultaneous pushes and pop on the integer pool
    step("R8 two pushes", 0, 0, 1, 3, 0, 0, 1, 4);
    chk("R8 two pushes count", int_free_cnt, 2);
    step("R8 pop+2 push", 1, 0, 1, 6, 0, 0, 1, 7);
    chk("R8 pop result", last_i, 3);
    chk("R8 net count", int_free_cnt, 3);
    step("R8 order", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 typed ahead 1", last_i, 4);
    step("R8 order", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 typed ahead 2", last_i, 6);
    step("R8 order", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 untyped last", last_i, 7);

    // R7: allocation on empty pool
    step("R7 empty req", 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 no grant", last_i >= 0 ? int'(int_alloc_vld) : 0, 0);
    chk("R7 err raised", alloc_err, 1);
    chk("R7 int pool unchanged", int_free_cnt, 0);
    for (int k = 0; k < 3; k++) step("R7 sticky", 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 err sticky", alloc_err, 1);
    do_reset();
    chk("R7 err cleared by reset", alloc_err, 0);

    // Random mix against the model
    for (int n = 0; n < 4000; n++) begin
      bit ai, af, ri, rf, ra;
      int vi = 0, vf = 0, va = 0;
      ai = ($urandom % 2 == 0) && iq.size() > 0;
      af = ($urandom % 2 == 0) && fq.size() > 0;
      ri = ($urandom % 3 == 0) && oi.size() > 0;
      if (ri) vi = oi.pop_front();
      rf = ($urandom % 3 == 0) && of_.size() > 0;
      if (rf) vf = of_.pop_front();
      ra = 0;
      if ($urandom % 3 == 0) begin
        if ($urandom % 2 == 0 && oi.size() > 0) begin ra = 1; va = oi.pop_front(); end
        else if (of_.size() > 0) begin ra = 1; va = of_.pop_front(); end
      end
      step("R8 random", ai, af, ri, vi, rf, vf, ra, va);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule